// File: doc/BRIEF.md
# Keyed Watchdog Timer with Two-Stage Expiry

The block is a watchdog for a processor subsystem. A free-running prescaler divides the system clock by a power of two (131072 by default, which turns 100 MHz into about 763 Hz). Software arms the watchdog and feeds it through one control-word write. The write carries an 8-bit start count, a start-or-stop command and a 7-bit key. While armed, the count falls by one on every prescaler tick.

Expiry happens in two stages. While the count stands at one, a non-maskable interrupt request is held high, which gives the handler one tick period to react. The tick that takes the count to zero ends the run and sends a one-cycle chip-reset pulse.

A write is honoured only if its key is the 7-bit complement of the key that the last honoured write carried. A program that has lost control is therefore unlikely to feed or stop the watchdog by chance. After power-on no key is held, and the first start is accepted with any key.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the watchdog is stopped with no key held, and both nmi_req and chip_rst are low. While no key is held, only a start (wr_cmd=1) is accepted, with any key. A stop in that state is ignored and leaves no key.
- R2: The prescaler counts every clock from reset and ticks once every 2^PRE_W cycles. The first tick falls on the edge that ends the 2^PRE_W-th cycle after reset is released.
- R3: An accepted start loads wr_count and runs the watchdog, and this also applies when it is already running. While running, each tick lowers the count by one.
- R4: Once a key is held, a write is accepted only if wr_key equals the held key XOR 7'h7F. Each accepted write stores its own key.
- R5: A write with a wrong key has no effect: the count, the run state, the held key and the outputs stay as they would have been without the write.
- R6: An accepted stop (wr_cmd=0) halts the count at the next edge, drops nmi_req and prevents a chip reset.
- R7: nmi_req is high exactly while the watchdog is running with count 1. This holds from the edge that makes it so until a reload, a stop or expiry.
- R8: A tick while running with count 1 (or a loaded count of 0) stops the watchdog and drives chip_rst high for exactly the following cycle.
- R9: An accepted write on the same edge as a tick takes precedence, and the tick does not act on the count in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Control-word write strobe, one cycle per write |
| wr_cmd | input | 1 | 1 = start or restart, 0 = stop |
| wr_count | input | CNT_W (8) | Start count loaded by a start |
| wr_key | input | 7 | Key that goes with the write |
| nmi_req | output | 1 | Non-maskable interrupt request, level |
| chip_rst | output | 1 | Chip-reset pulse, one cycle |

## Verification
The assertions assume that wr_en is a single-cycle strobe sampled at the clock edge. They also assume that wr_cmd, wr_count and wr_key are stable whenever wr_en is high, and that rst_n is released away from a clock edge. The bench changes every input on the falling edge and keeps each write one cycle long. It produces correct keys from its own record of the key chain, so the key rule always sees a well-defined previous key. Wrong keys are made by XORing a nonzero value into the correct one. This means a write meant to be rejected never matches by accident.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int KEY_W = 7;

  typedef enum logic {
    WD_STOP  = 1'b0,
    WD_START = 1'b1
  } wd_cmd_e;

  // key a following write must carry
  function automatic logic [KEY_W-1:0] next_key(input logic [KEY_W-1:0] held);
    return held ^ {KEY_W{1'b1}};
  endfunction

  // acceptance rule for a control write
  function automatic logic write_ok(input logic armed, input logic [KEY_W-1:0] held,
                                    input logic cmd, input logic [KEY_W-1:0] key);
    if (!armed) return (cmd == WD_START);
    return key == next_key(held);
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 17
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick = &pre_q;
endmodule

// File: rtl/wdt_keygate.sv
module wdt_keygate
  import keyed_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_cmd,
  input  logic [KEY_W-1:0] wr_key,
  output logic             accept_start,
  output logic             accept_stop,
  output logic [KEY_W-1:0] key_q,
  output logic             armed_q
);
  logic accepted;

  assign accepted     = wr_en && write_ok(armed_q, key_q, wr_cmd, wr_key);
  assign accept_start = accepted && (wr_cmd == WD_START);
  assign accept_stop  = accepted && (wr_cmd == WD_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      armed_q <= 1'b0;
    end else if (accepted) begin
      key_q   <= wr_key;
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             halt,
  input  logic [CNT_W-1:0] load_val,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic             expire_evt,
  output logic             nmi_req,
  output logic             chip_rst
);
  function automatic logic is_final(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  logic rst_q;

  assign expire_evt = running && tick && !load && !halt && is_final(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
      rst_q   <= 1'b0;
    end else begin
      rst_q <= expire_evt;
      if (load) begin
        running <= 1'b1;
        count   <= load_val;
      end else if (halt) begin
        running <= 1'b0;
      end else if (expire_evt) begin
        running <= 1'b0;
        count   <= '0;
      end else if (running && tick) begin
        count <= count - 1'b1;
      end
    end
  end

  assign nmi_req  = running && (count == CNT_W'(1));
  assign chip_rst = rst_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_cmd,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [KEY_W-1:0] wr_key,
  output logic             nmi_req,
  output logic             chip_rst
);
  logic             tick;
  logic             accept_start;
  logic             accept_stop;
  logic [KEY_W-1:0] key_q;
  logic             armed_q;
  logic             running;
  logic [CNT_W-1:0] count;
  logic             expire_evt;

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  wdt_keygate u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_key(wr_key),
    .accept_start(accept_start), .accept_stop(accept_stop),
    .key_q(key_q), .armed_q(armed_q)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(accept_start), .halt(accept_stop),
    .load_val(wr_count), .running(running), .count(count), .expire_evt(expire_evt),
    .nmi_req(nmi_req), .chip_rst(chip_rst)
  );
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
  import keyed_wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] wr_count,
  input logic             tick,
  input logic             accept_start,
  input logic             accept_stop,
  input logic             wr_en,
  input logic [KEY_W-1:0] key_q,
  input logic             armed_q,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic             nmi_req,
  input logic             chip_rst
);
  a_r1_idle_until_keyed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !running);

  a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> (running && count == $past(wr_count)));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !accept_start && !accept_stop && count > CNT_W'(1))
      |=> (count == $past(count) - CNT_W'(1)));

  a_r5_key_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !accept_start && !accept_stop) |=> ($stable(key_q) && $stable(armed_q)));

  a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
    accept_stop |=> (!running && !nmi_req && !chip_rst));

  a_r7_nmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !tick && !accept_start && !accept_stop) |=> nmi_req);

  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> !chip_rst);

  a_r8_halted: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> (!running && !nmi_req));
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_count(wr_count), .tick(tick),
  .accept_start(accept_start), .accept_stop(accept_stop), .wr_en(wr_en),
  .key_q(key_q), .armed_q(armed_q), .running(running), .count(count),
  .nmi_req(nmi_req), .chip_rst(chip_rst)
);

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
  localparam int PW = 3;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_cmd = 1'b0;
  logic [7:0] wr_count = '0;
  logic [6:0] wr_key = '0;
  logic       nmi_req, chip_rst;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string phase = "R1";

  always #4 clk = ~clk;

  keyed_wdt #(.CNT_W(8), .PRE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
    .wr_count(wr_count), .wr_key(wr_key), .nmi_req(nmi_req), .chip_rst(chip_rst)
  );

  // acceptance as the requirements state it
  function automatic bit good_key(bit armed, logic [6:0] held, bit cmd, logic [6:0] k);
    if (!armed) return cmd;
    return (k ^ held) == 7'h7F;
  endfunction

  // behavioural model built from R1..R9
  logic [PW-1:0] m_pre;
  bit            m_run, m_armed, m_rst;
  logic [7:0]    m_cnt;
  logic [6:0]    m_key;

  always @(posedge clk or negedge rst_n) begin
    bit tk;
    if (!rst_n) begin
      m_pre <= '0; m_run <= 0; m_armed <= 0; m_rst <= 0; m_cnt <= '0; m_key <= '0;
    end else begin
      tk = (m_pre == {PW{1'b1}});
      m_pre <= m_pre + 1'b1;
      m_rst <= 1'b0;
      if (wr_en && good_key(m_armed, m_key, wr_cmd, wr_key)) begin
        m_key <= wr_key; m_armed <= 1'b1;
        if (wr_cmd) begin m_run <= 1'b1; m_cnt <= wr_count; end
        else m_run <= 1'b0;
      end else if (m_run && tk) begin
        if (m_cnt < 8'd2) begin m_run <= 1'b0; m_cnt <= '0; m_rst <= 1'b1; end
        else m_cnt <= m_cnt - 8'd1;
      end
    end
  end

  task automatic check(input bit got, input bit exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", phase, what, got, exp, $time);
    end
  endtask

  // lockstep comparison, phase names the requirement under test
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(nmi_req, m_run && (m_cnt == 8'd1), "nmi_req (R7)");
      check(chip_rst, m_rst, "chip_rst (R8)");
    end
  end

  bit         tb_armed = 0;
  logic [6:0] tb_key = '0;

  task automatic put(input bit cmd, input logic [7:0] c, input logic [6:0] k);
    wr_en = 1'b1; wr_cmd = cmd; wr_count = c; wr_key = k;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic good(input bit cmd, input logic [7:0] c);
    logic [6:0] k;
    if (!tb_armed) begin
      k = 7'($urandom);
      if (cmd) begin tb_armed = 1; tb_key = k; end
    end else begin
      k = tb_key ^ 7'h7F;
      tb_key = k;
    end
    put(cmd, c, k);
  endtask

  task automatic bad(input bit cmd, input logic [7:0] c);
    logic [6:0] k;
    k = (tb_key ^ 7'h7F) ^ 7'(1 + ($urandom % 127));
    put(cmd, c, k);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(1);
    phase = "R1";
    check(nmi_req, 1'b0, "nmi after reset (R1)");
    check(chip_rst, 1'b0, "rst after reset (R1)");
    put(1'b0, 8'd2, 7'($urandom));   // stop with no key held: ignored
    idle(30);
    phase = "R2"; good(1'b1, 8'd3); idle(50);
    phase = "R3"; good(1'b1, 8'd4); idle(12); good(1'b1, 8'd3); idle(50);
    phase = "R7"; good(1'b1, 8'd1);
    check(nmi_req, 1'b1, "nmi on load of 1 (R7)");
    idle(20);
    phase = "R8"; good(1'b1, 8'd0); idle(20);
    phase = "R5"; good(1'b1, 8'd5); bad(1'b0, 8'd0); idle(3); bad(1'b1, 8'd9); idle(70);
    phase = "R6"; good(1'b1, 8'd2); idle(10); good(1'b0, 8'd0); idle(40);
    phase = "R9";
    while (m_pre != {PW{1'b1}}) @(negedge clk);
    good(1'b1, 8'd2);
    idle(40);
    phase = "R4";
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 5)
        0, 1: good(1'b1, 8'($urandom % 6));
        2: good(1'b0, 8'($urandom));
        3: bad(1'($urandom), 8'($urandom % 6));
        default: ;
      endcase
      idle($urandom % 24);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired in phase %s: got running expected finished", phase);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule